// File: doc/BRIEF.md
# Converter Readout Host Controller

This block is the host side of a four-wire serial link to a multiplexed sigma-delta converter. When a request comes in, it pulls the chip-select low with the serial clock parked low, so the converter is placed in externally clocked mode. It then treats the converter's data line as an end-of-conversion flag and polls it. Once that line reads low, the block generates the serial clock and runs one frame of 1 to 32 bits. Each result bit is captured on a rising clock edge. During the same frame the block sends the channel-select word that the converter will use for its next conversion.

A frame shorter than 32 bits is ended by raising chip-select after the requested number of bits. On the converter side this aborts the readout and starts a new conversion. The captured bits come back left-aligned, together with the sign bit, an error flag and a one-cycle done strobe. The request side is a plain valid/ready pair, and a request is taken only when the controller is idle. The serial clock half-period is a parameter counted in system clock cycles.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, sdi is 0, req_ready is 1 and rsp_valid is 0.
- R2: Whenever cs_n falls, sck is 0.
- R3: While cs_n is low and no bit has been clocked yet, sck stays low for as long as sdo reads 1. The first sck rising edge comes only after sdo has been sampled at 0.
- R4: On successive sck rising edges, sdi carries a 1, then req_cmd[5] down to req_cmd[0], and 0 after that. sdi changes only while sck is low.
- R5: Each frame bit is sampled from sdo at an sck rising edge. rsp_frame[31] holds the first bit, the following bits sit below it, and every bit position beyond the frame length reads 0.
- R6: A frame has exactly req_len sck rising edges. A req_len of 0, or of more than 32, gives 32 edges.
- R7: cs_n rises one half-period after the last sck falling edge. rsp_valid is a one-cycle pulse in the same cycle that cs_n rises.
- R8: Between frames, cs_n stays high for at least two half-periods. req_ready is 1 only in idle. A request made while a frame is in progress has no effect.
- R9: rsp_err is 1 when rsp_frame[31] is 1 (the flag bit) or rsp_frame[30] is 1 (the dummy bit). rsp_sign equals rsp_frame[29].
- R10: Every sck high phase lasts exactly HALF_DIV clk cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame request |
| req_ready | output | 1 | Controller idle; a request is taken |
| req_cmd | input | CMD_W | Channel-select bits {enable, single-ended, odd/sign, address[2:0]} |
| req_len | input | LEN_W | Frame length in bits (0 or >32 means 32) |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| sdi | output | 1 | Serial data to the converter |
| sdo | input | 1 | Serial data / end-of-conversion from the converter |
| rsp_valid | output | 1 | One-cycle done strobe |
| rsp_frame | output | FRAME_W | Captured bits, left-aligned |
| rsp_sign | output | 1 | Sign bit of the result |
| rsp_err | output | 1 | Flag or dummy bit was 1 |

## Verification
A behavioural converter model stays busy for a fixed time after every conversion start, so every frame begins with a polling phase. Frames of 32, 31, 7, 3, 2 and 1 bits, plus lengths of 0 and 40, are run against data words chosen to tell left alignment apart from right alignment and to separate full frames from aborted ones. Data words with the dummy bit set are read once at length 1, where the bit falls outside the frame and no error may appear, and once at length 2, where the error must appear. A request pulsed during a frame with a different channel word shows whether busy-time requests leak into the sdi stream or produce an extra strobe.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GAP
  } rd_state_t;
endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick = en;
    end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !en) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = en && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int FRAME_W = 32,
  parameter int CMD_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CMD_W-1:0]   cmd,
  input  logic               step,
  input  logic               din,
  output logic               tx_msb,
  output logic [FRAME_W-1:0] rx
);
  localparam int PAD = FRAME_W - 1 - CMD_W;
  logic [FRAME_W-1:0] tx_q;
  logic [FRAME_W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= {1'b1, cmd, {PAD{1'b0}}};
      rx_q <= '0;
    end else if (step) begin
      tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      rx_q <= {rx_q[FRAME_W-2:0], din};
    end
  end

  assign tx_msb = tx_q[FRAME_W-1];
  assign rx     = rx_q;
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int FRAME_W  = 32,
  parameter int CMD_W    = 6,
  parameter int LEN_W    = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CMD_W-1:0]   req_cmd,
  input  logic [LEN_W-1:0]   req_len,
  output logic               cs_n,
  output logic               sck,
  output logic               sdi,
  input  logic               sdo,
  output logic               rsp_valid,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic               rsp_sign,
  output logic               rsp_err
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(FRAME_W);

  rd_state_t          state;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   bit_q;
  logic [LEN_W-1:0]   len_eff;
  logic               gap_q;
  logic               tick;
  logic               load;
  logic               step;
  logic               tx_msb;
  logic [FRAME_W-1:0] rx_bits;
  logic [FRAME_W-1:0] aligned;

  always_comb begin
    if (req_len == '0 || req_len > FULL_LEN) len_eff = FULL_LEN;
    else len_eff = req_len;
  end

  assign load      = (state == ST_IDLE) && req_valid;
  assign step      = (state == ST_LOW) && tick;
  assign aligned   = rx_bits << (FULL_LEN - len_q);
  assign req_ready = (state == ST_IDLE);

  adc_rd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (state != ST_IDLE),
    .tick (tick)
  );

  adc_rd_shift #(.FRAME_W(FRAME_W), .CMD_W(CMD_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .cmd    (req_cmd),
    .step   (step),
    .din    (sdo),
    .tx_msb (tx_msb),
    .rx     (rx_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      sck       <= 1'b0;
      sdi       <= 1'b0;
      len_q     <= '0;
      bit_q     <= '0;
      gap_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_frame <= '0;
      rsp_sign  <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            len_q <= len_eff;
            cs_n  <= 1'b0;
            state <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (tick && !sdo) begin
            sdi   <= tx_msb;
            bit_q <= '0;
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sck   <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sck <= 1'b0;
            if (bit_q == len_q - 1'b1) begin
              sdi   <= 1'b0;
              state <= ST_TAIL;
            end else begin
              bit_q <= bit_q + 1'b1;
              sdi   <= tx_msb;
              state <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n      <= 1'b1;
            rsp_valid <= 1'b1;
            rsp_frame <= aligned;
            rsp_err   <= aligned[FRAME_W-1] | aligned[FRAME_W-2];
            rsp_sign  <= aligned[FRAME_W-3];
            gap_q     <= 1'b0;
            state     <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_q) state <= ST_IDLE;
            else gap_q <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
module adc_readout_ctrl_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic cs_n,
  input logic sck,
  input logic sdi,
  input logic rsp_valid
);
  logic [15:0] hi_cnt;
  logic [15:0] cs_hi_cnt;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      cs_hi_cnt <= '0;
      seen      <= 1'b0;
    end else begin
      hi_cnt <= sck ? hi_cnt + 1'b1 : '0;
      if (!cs_n) cs_hi_cnt <= '0;
      else if (cs_hi_cnt != 16'hFFFF) cs_hi_cnt <= cs_hi_cnt + 1'b1;
      if (rsp_valid) seen <= 1'b1;
    end
  end

  p_cs_fall_sck_low_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !sck);

  p_sck_inside_frame_r3: assert property (@(posedge clk) disable iff (rst)
    sck |-> !cs_n);

  p_sdi_steady_high_r4: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(sdi));

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_strobe_with_cs_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $rose(cs_n));

  p_cs_gap_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && seen) |-> (cs_hi_cnt >= 16'(2 * HALF_DIV)));

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (cs_n && !sck));

  p_high_phase_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(sck) |-> (hi_cnt == 16'(HALF_DIV)));
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .cs_n      (cs_n),
  .sck       (sck),
  .sdi       (sdi),
  .rsp_valid (rsp_valid)
);

// File: tb/sim_adc_readout_ctrl.sv
`timescale 1ns/1ps
module sim_adc_readout_ctrl;
  localparam int HALF = 2;
  localparam int CONV = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_cmd = '0;
  logic [5:0]  req_len = '0;
  logic        cs_n, sck, sdi;
  logic        sdo_r = 1'b1;
  logic        rsp_valid;
  logic [31:0] rsp_frame;
  logic        rsp_sign, rsp_err;

  int checks = 0;
  int errors = 0;
  int frames_out = 0;
  int frames_in = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_readout_ctrl #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_len(req_len), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo_r), .rsp_valid(rsp_valid), .rsp_frame(rsp_frame),
    .rsp_sign(rsp_sign), .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // converter model
  logic [31:0] slave_word = '0;
  logic [31:0] sh = '0;
  logic [31:0] sdi_rec = '0;
  logic        busy = 1'b1, in_data = 1'b0, sck_p = 1'b0, cs_p = 1'b1;
  int conv_left = CONV, fall_n = 0, rise_n = 0, poll_viol = 0;

  always @(posedge clk) begin
    if (rst) begin
      busy = 1'b1; conv_left = CONV; in_data = 1'b0;
      sck_p = 1'b0; cs_p = 1'b1; sdo_r <= 1'b1;
    end else begin
      if (!cs_n && cs_p) begin rise_n = 0; sdi_rec = '0; end
      if (busy) begin
        if (conv_left == 0) busy = 1'b0;
        else conv_left--;
      end
      if (!cs_n && sck && !sck_p) begin
        if (busy && !in_data) poll_viol++;
        if (!in_data && !busy) begin
          in_data = 1'b1; sh = {1'b0, slave_word[30:0]}; fall_n = 0;
        end
        sdi_rec = {sdi_rec[30:0], sdi};
        rise_n++;
      end
      if (!cs_n && !sck && sck_p && in_data) begin
        fall_n++;
        if (fall_n == 32) begin in_data = 1'b0; busy = 1'b1; conv_left = CONV; end
        else sh = sh << 1;
      end
      if (cs_n && !cs_p && in_data) begin
        in_data = 1'b0; busy = 1'b1; conv_left = CONV;
      end
      sdo_r <= cs_n ? 1'b1 : (in_data ? sh[31] : busy);
      sck_p = sck; cs_p = cs_n;
    end
  end

  typedef struct {
    logic [31:0] fr;
    logic        err;
    logic        sign;
    logic [31:0] sdi_exp;
    int          le;
  } exp_t;
  exp_t q[$];

  task automatic run_frame(input logic [5:0] cmd, input logic [5:0] len, input logic [31:0] word);
    exp_t e;
    logic [31:0] full;
    logic [31:0] seq;
    e.le = (len == 0 || len > 32) ? 32 : int'(len);
    full = {1'b0, word[30:0]};
    e.fr = (e.le == 32) ? full : ((full >> (32 - e.le)) << (32 - e.le));
    e.err = e.fr[31] | e.fr[30];
    e.sign = e.fr[29];
    seq = {1'b1, cmd, 25'd0};
    e.sdi_exp = (e.le == 32) ? seq : (seq >> (32 - e.le));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    slave_word = word;
    q.push_back(e);
    frames_in++;
    req_cmd = cmd; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      frames_out++;
      if (q.size() == 0) begin
        chk(1'b0, "R8 unexpected strobe", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_frame == e.fr, "R5 frame", rsp_frame, e.fr);
        chk(rsp_err == e.err, "R9 err", {31'd0, rsp_err}, {31'd0, e.err});
        chk(rsp_sign == e.sign, "R9 sign", {31'd0, rsp_sign}, {31'd0, e.sign});
        chk(rise_n == e.le, "R6 edge count", rise_n, e.le);
        chk(sdi_rec == e.sdi_exp, "R4 sdi bits", sdi_rec, e.sdi_exp);
        chk(poll_viol == 0, "R3 clock while busy", poll_viol, 0);
      end
    end
  end

  // phase and gap timing at the pins
  int hi_run = 0, cs_run = 0;
  bit sck_o = 0, cs_o = 1, seen = 0;
  always @(negedge clk) begin
    if (rst) begin
      hi_run = 0; cs_run = 0; sck_o = 0; cs_o = 1; seen = 0;
    end else begin
      if (!sck && sck_o) chk(hi_run == HALF, "R10 high phase", hi_run, HALF);
      if (!cs_n && cs_o && seen) chk(cs_run >= 2 * HALF, "R8 cs gap", cs_run, 2 * HALF);
      if (!cs_n && cs_o) chk(!sck, "R2 sck at cs fall", {31'd0, sck}, 32'd0);
      hi_run = sck ? hi_run + 1 : 0;
      cs_run = cs_n ? cs_run + 1 : 0;
      if (rsp_valid) seen = 1;
      sck_o = sck; cs_o = cs_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", {31'd0, cs_n}, 32'd1);
    chk(sck == 1'b0, "R1 sck", {31'd0, sck}, 32'd0);
    chk(sdi == 1'b0, "R1 sdi", {31'd0, sdi}, 32'd0);
    chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid == 1'b0, "R1 valid", {31'd0, rsp_valid}, 32'd0);

    run_frame(6'b101011, 6'd32, 32'h1A5C_3E71);
    // R3: during the polling phase sck must stay low
    repeat (10) @(negedge clk);
    chk(!cs_n && !sck, "R3 polling idle clock", {30'd0, cs_n, sck}, 32'd0);
    run_frame(6'b110101, 6'd7, 32'h2F00_FFFF);
    run_frame(6'b011100, 6'd3, 32'h3123_4567);
    run_frame(6'b100001, 6'd1, 32'h7FFF_FFFF);   // R9 dummy outside frame
    run_frame(6'b111111, 6'd2, 32'h4000_0000);   // R9 dummy inside frame
    run_frame(6'b000110, 6'd0, 32'h0ABC_DEF0);   // R6 zero means full
    run_frame(6'b010101, 6'd40, 32'h1357_9BDF);  // R6 over-length means full
    run_frame(6'b001011, 6'd31, 32'h3FFF_FFFF);

    // R8: request while busy has no effect
    run_frame(6'b100110, 6'd32, 32'h0246_8ACE);
    repeat (20) @(negedge clk);
    chk(req_ready == 1'b0, "R8 ready while busy", {31'd0, req_ready}, 32'd0);
    req_cmd = 6'b011001; req_len = 6'd4; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;

    @(negedge clk);
    while (!req_ready || q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(frames_out == frames_in, "R8 strobe count", frames_out, frames_in);
    chk(cs_n == 1'b1, "R7 cs high after frames", {31'd0, cs_n}, 32'd1);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule